// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns two encoder phase inputs and an index input into a position count, a counting-direction flag and a revolution count. It has two signal modes. In quadrature mode the two inputs are phase-shifted square waves. In step/direction mode one input is a count clock and the other gives the direction. In quadrature mode it also counts at either of two rates: edges of phase A only, or edges of both phases. Every input first passes a synchronizer and then a digital filter. The filter accepts a new level only after it has seen that level for a programmable number of consecutive samples.

The position counter runs between 0 and a programmable maximum and wraps at both ends. A direction-invert bit reverses the counting sense and an index-polarity bit selects which index edge is active. Single-cycle pulses report these events: each accepted count, each change of direction, illegal quadrature transitions, index detection, matches of the position against three compare values and a match of the revolution count against its own compare value. Strobes clear the position, arm a position clear on the next index, and clear the revolution count. A velocity-reset strobe is only delayed by one register and passed on to a neighbouring velocity unit.

Top module: `qenc_counter`

## Requirements
- R1: In quadrature mode (`cfg_stepdir`=0) with `cfg_x4`=1, every filtered edge of a single phase changes the position by one. The phase sequence (A,B) = 00→10→11→01→00, with A leading, counts up, and the reverse sequence counts down.
- R2: With `cfg_x4`=0 in quadrature mode, only edges of phase A change the position, so four successive quadrature steps move it by two.
- R3: In step/direction mode (`cfg_stepdir`=1), each rising edge of filtered phase A is one count. It counts up when B is 0 and down when B is 1. Falling edges of A and any change of B do not count.
- R4: With `cfg_dir_inv`=1, the decoded direction is complemented both for the counter and for `dir_rev`.
- R5: Counting up from `max_pos` gives 0, and counting down from 0 gives `max_pos`.
- R6: When both filtered phases change in the same sample in quadrature mode, `phase_err` pulses for one cycle and the position does not change.
- R7: `dir_rev` (1 = reverse, 0 after reset) holds the direction of the last accepted count. `dir_chg` pulses for one cycle when that direction changes.
- R8: A filtered input takes a new level only after `flt_len` consecutive samples at that level. A shorter glitch has no effect on the position.
- R9: A rising edge of the index input, after XOR with `cfg_idx_inv`, pulses `idx_seen` and increments `rev_cnt`. `clr_idx` clears `rev_cnt`. `rev_match` pulses when `rev_cnt` is updated to a value equal to `cmp_idx`.
- R10: `clr_pos` clears the position. `arm_idx_clr` arms a one-time clear of the position on the next index event. The armed clear takes priority over a count in the same cycle.
- R11: Compare channel i (`cmp_pos[i*POS_W +: POS_W]`) pulses `pos_match[i]` for one cycle whenever the position is updated to a value equal to that channel's compare value.
- R12: `enc_clk` pulses once for every accepted count event. `vel_rst_out` follows `vel_rst_in` one cycle later.
- R13: After reset, the position, revolution count, `dir_rev` and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_stepdir | input | 1 | 0 = quadrature, 1 = step/direction |
| cfg_x4 | input | 1 | 1 = count both phases, 0 = phase A only |
| cfg_dir_inv | input | 1 | Complement decoded direction |
| cfg_idx_inv | input | 1 | Invert index polarity |
| flt_len | input | FLT_W | Samples needed to accept a new input level |
| max_pos | input | POS_W | Highest position value |
| cmp_pos | input | NCMP*POS_W | Position compare values, channel i at bits i*POS_W |
| cmp_idx | input | IDX_W | Revolution compare value |
| clr_pos | input | 1 | Clear position strobe |
| arm_idx_clr | input | 1 | Arm position clear on next index |
| clr_idx | input | 1 | Clear revolution count strobe |
| vel_rst_in | input | 1 | Velocity reset strobe to pass on |
| enc_a | input | 1 | Phase A / step input |
| enc_b | input | 1 | Phase B / direction input |
| enc_idx | input | 1 | Index input |
| pos_cnt | output | POS_W | Position count |
| rev_cnt | output | IDX_W | Revolution count |
| dir_rev | output | 1 | Current direction, 1 = reverse |
| dir_chg | output | 1 | Direction change pulse |
| enc_clk | output | 1 | Accepted count event pulse |
| phase_err | output | 1 | Illegal transition pulse |
| idx_seen | output | 1 | Index event pulse |
| pos_match | output | NCMP | Per-channel position match pulses |
| rev_match | output | 1 | Revolution compare match pulse |
| vel_rst_out | output | 1 | Delayed velocity reset strobe |

## Verification
An armed index clear and an ordinary quadrature count can arrive in the same cycle. The bench provokes this by changing phase A and raising the index at the same bench edge. Both inputs then take the same filter latency and reach the counter together. The result is correct if the position reads 0, not the incremented value, and if the next step reads 1, which shows that the arm was used up. A second coincidence is a simultaneous change of both phases: the error pulse must fire while the position and the `enc_clk` tally stay unchanged.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic {
        SIG_QUAD    = 1'b0,
        SIG_STEPDIR = 1'b1
    } sig_mode_e;

    // Forward direction of a single-phase quadrature move, given the new levels.
    function automatic logic quad_fwd(input logic a, input logic b, input logic a_moved);
        return a_moved ? (a ^ b) : ~(a ^ b);
    endfunction

endpackage

// File: rtl/qenc_filt.sv
module qenc_filt #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [LEN_W-1:0] len,
    output logic             lvl
);
    localparam logic [LEN_W:0] ONE = 1;

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic [LEN_W-1:0] run;
    } filt_t;

    filt_t        st_d, st_q;
    logic [LEN_W:0] run_inc;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        run_inc = {1'b0, st_q.run} + ONE;
        if (st_q.s2 != st_q.lvl) begin
            if (run_inc >= {1'b0, len}) begin
                st_d.lvl = st_q.s2;
                st_d.run = '0;
            end else begin
                st_d.run = run_inc[LEN_W-1:0];
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.lvl;

    // R8: an accepted level is always the level last seen in the sample stage
    p_accept_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |-> ($past(st_q.s2) == st_q.lvl));

    // R8: a level change with a length above one needs a running count first
    p_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.lvl != $past(st_q.lvl)) && ($past(len) > 1)) |-> ($past(st_q.run) != '0));

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    input  logic ix,
    input  logic cfg_stepdir,
    input  logic cfg_x4,
    input  logic cfg_dir_inv,
    input  logic cfg_idx_inv,
    output logic cnt_ev,
    output logic cnt_up,
    output logic phase_err,
    output logic dir_rev,
    output logic dir_chg,
    output logic idx_ev
);
    typedef struct packed {
        logic pa;
        logic pb;
        logic pidx;
        logic ev;
        logic up;
        logic err;
        logic rev;
        logic chg;
        logic iev;
    } dec_t;

    dec_t st_d, st_q;
    logic moved_a, moved_b, raw_fwd, eff_fwd, hit, bad, eff_idx;

    always_comb begin
        st_d    = st_q;
        moved_a = a ^ st_q.pa;
        moved_b = b ^ st_q.pb;
        hit     = 1'b0;
        bad     = 1'b0;
        raw_fwd = 1'b1;
        if (sig_mode_e'(cfg_stepdir) == SIG_STEPDIR) begin
            hit     = a & ~st_q.pa;
            raw_fwd = ~b;
        end else if (moved_a && moved_b) begin
            bad = 1'b1;
        end else if (moved_a) begin
            hit     = 1'b1;
            raw_fwd = quad_fwd(a, b, 1'b1);
        end else if (moved_b) begin
            hit     = cfg_x4;
            raw_fwd = quad_fwd(a, b, 1'b0);
        end
        eff_fwd  = raw_fwd ^ cfg_dir_inv;
        st_d.pa  = a;
        st_d.pb  = b;
        st_d.ev  = hit;
        st_d.up  = eff_fwd;
        st_d.err = bad;
        st_d.chg = hit && (~eff_fwd != st_q.rev);
        if (hit) st_d.rev = ~eff_fwd;
        eff_idx   = ix ^ cfg_idx_inv;
        st_d.pidx = eff_idx;
        st_d.iev  = eff_idx & ~st_q.pidx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_ev    = st_q.ev;
    assign cnt_up    = st_q.up;
    assign phase_err = st_q.err;
    assign dir_rev   = st_q.rev;
    assign dir_chg   = st_q.chg;
    assign idx_ev    = st_q.iev;

    // R6: an error sample never produces a count
    p_err_no_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |-> !cnt_ev);

    // R7: a change pulse coincides with a flip of the direction status
    p_dirchg_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dir_chg |-> (dir_rev != $past(dir_rev)));

    // R7: direction status moves only together with a count
    p_dir_on_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_ev |-> (dir_rev == $past(dir_rev)));

    // R3: step/direction mode never reports a phase error
    p_step_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_stepdir) |-> !phase_err);

endmodule

// File: rtl/qenc_track.sv
module qenc_track #(
    parameter int POS_W = 16,
    parameter int IDX_W = 8,
    parameter int NCMP  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cnt_ev,
    input  logic                  cnt_up,
    input  logic                  idx_ev,
    input  logic                  clr_pos,
    input  logic                  arm_idx_clr,
    input  logic                  clr_idx,
    input  logic                  vel_in,
    input  logic [POS_W-1:0]      max_pos,
    input  logic [NCMP*POS_W-1:0] cmp_pos,
    input  logic [IDX_W-1:0]      cmp_idx,
    output logic [POS_W-1:0]      pos,
    output logic [IDX_W-1:0]      idx,
    output logic [NCMP-1:0]       pos_match,
    output logic                  idx_match,
    output logic                  vel_out
);
    localparam logic [POS_W-1:0] P_ONE = 1;
    localparam logic [IDX_W-1:0] I_ONE = 1;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [IDX_W-1:0] idx;
        logic             armed;
        logic [NCMP-1:0]  pmatch;
        logic             imatch;
        logic             vel;
    } trk_t;

    trk_t             st_d, st_q;
    logic [POS_W-1:0] pos_nx;
    logic [IDX_W-1:0] idx_nx;
    logic             pos_upd, idx_upd;
    logic [NCMP-1:0]  cmp_hit;

    always_comb begin
        pos_nx  = st_q.pos;
        pos_upd = 1'b0;
        if (clr_pos) begin
            pos_nx  = '0;
            pos_upd = 1'b1;
        end else if (idx_ev && st_q.armed) begin
            pos_nx  = '0;
            pos_upd = 1'b1;
        end else if (cnt_ev) begin
            pos_upd = 1'b1;
            if (cnt_up) pos_nx = (st_q.pos == max_pos) ? '0 : st_q.pos + P_ONE;
            else        pos_nx = (st_q.pos == '0) ? max_pos : st_q.pos - P_ONE;
        end
        idx_nx  = st_q.idx;
        idx_upd = clr_idx | idx_ev;
        if (clr_idx)     idx_nx = '0;
        else if (idx_ev) idx_nx = st_q.idx + I_ONE;
    end

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        assign cmp_hit[g] = pos_upd && (pos_nx == cmp_pos[g*POS_W +: POS_W]);
    end

    always_comb begin
        st_d        = st_q;
        st_d.pos    = pos_nx;
        st_d.idx    = idx_nx;
        st_d.pmatch = cmp_hit;
        st_d.imatch = idx_upd && (idx_nx == cmp_idx);
        st_d.vel    = vel_in;
        if (idx_ev)      st_d.armed = 1'b0;
        if (arm_idx_clr) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos       = st_q.pos;
    assign idx       = st_q.idx;
    assign pos_match = st_q.pmatch;
    assign idx_match = st_q.imatch;
    assign vel_out   = st_q.vel;

    // R10: a clear strobe always leaves the position at zero
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pos |=> (pos == '0));

    // R5: counting up from the maximum wraps to zero
    p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ev && cnt_up && !clr_pos && !(idx_ev && st_q.armed) && pos == max_pos) |=> (pos == '0));

    // R5: counting down from zero loads the maximum
    p_wrap_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ev && !cnt_up && !clr_pos && !(idx_ev && st_q.armed) && pos == '0) |=> (pos == $past(max_pos)));

    // R9: a revolution match pulse shows the compare value in the counter
    p_rev_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_match |-> (idx == $past(cmp_idx)));

    for (genvar g = 0; g < NCMP; g++) begin : g_chk
        // R11: a channel pulse shows that channel's compare value in the counter
        p_pos_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
            pos_match[g] |-> (pos == $past(cmp_pos[g*POS_W +: POS_W])));
    end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
    parameter int POS_W = 16,
    parameter int IDX_W = 8,
    parameter int FLT_W = 4,
    parameter int NCMP  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_stepdir,
    input  logic                  cfg_x4,
    input  logic                  cfg_dir_inv,
    input  logic                  cfg_idx_inv,
    input  logic [FLT_W-1:0]      flt_len,
    input  logic [POS_W-1:0]      max_pos,
    input  logic [NCMP*POS_W-1:0] cmp_pos,
    input  logic [IDX_W-1:0]      cmp_idx,
    input  logic                  clr_pos,
    input  logic                  arm_idx_clr,
    input  logic                  clr_idx,
    input  logic                  vel_rst_in,
    input  logic                  enc_a,
    input  logic                  enc_b,
    input  logic                  enc_idx,
    output logic [POS_W-1:0]      pos_cnt,
    output logic [IDX_W-1:0]      rev_cnt,
    output logic                  dir_rev,
    output logic                  dir_chg,
    output logic                  enc_clk,
    output logic                  phase_err,
    output logic                  idx_seen,
    output logic [NCMP-1:0]       pos_match,
    output logic                  rev_match,
    output logic                  vel_rst_out
);
    localparam int NIN = 3;

    logic [NIN-1:0] raw_in, flt_out;
    logic           cnt_ev, cnt_up, idx_ev;

    assign raw_in = {enc_idx, enc_b, enc_a};

    for (genvar g = 0; g < NIN; g++) begin : g_flt
        qenc_filt #(.LEN_W(FLT_W)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_in[g]),
            .len   (flt_len),
            .lvl   (flt_out[g])
        );
    end

    qenc_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .a           (flt_out[0]),
        .b           (flt_out[1]),
        .ix          (flt_out[2]),
        .cfg_stepdir (cfg_stepdir),
        .cfg_x4      (cfg_x4),
        .cfg_dir_inv (cfg_dir_inv),
        .cfg_idx_inv (cfg_idx_inv),
        .cnt_ev      (cnt_ev),
        .cnt_up      (cnt_up),
        .phase_err   (phase_err),
        .dir_rev     (dir_rev),
        .dir_chg     (dir_chg),
        .idx_ev      (idx_ev)
    );

    qenc_track #(.POS_W(POS_W), .IDX_W(IDX_W), .NCMP(NCMP)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_ev      (cnt_ev),
        .cnt_up      (cnt_up),
        .idx_ev      (idx_ev),
        .clr_pos     (clr_pos),
        .arm_idx_clr (arm_idx_clr),
        .clr_idx     (clr_idx),
        .vel_in      (vel_rst_in),
        .max_pos     (max_pos),
        .cmp_pos     (cmp_pos),
        .cmp_idx     (cmp_idx),
        .pos         (pos_cnt),
        .idx         (rev_cnt),
        .pos_match   (pos_match),
        .idx_match   (rev_match),
        .vel_out     (vel_rst_out)
    );

    assign enc_clk  = cnt_ev;
    assign idx_seen = idx_ev;

    // R12: every count pulse comes with a position update one cycle later
    p_count_moves_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_clk && !clr_pos && !(idx_seen) && max_pos != '0) |=> (pos_cnt != $past(pos_cnt)));

endmodule

// File: tb/sim_qenc_counter.sv
module sim_qenc_counter;
    localparam int POS_W = 16;
    localparam int IDX_W = 8;
    localparam int FLT_W = 4;
    localparam int NCMP  = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_stepdir = 0, cfg_x4 = 1, cfg_dir_inv = 0, cfg_idx_inv = 0;
    logic [FLT_W-1:0] flt_len = 4'd2;
    logic [POS_W-1:0] max_pos = 16'd1000;
    logic [POS_W-1:0] c0 = 16'd900, c1 = 16'd901, c2 = 16'd902;
    logic [IDX_W-1:0] cmp_idx = 8'd200;
    logic clr_pos = 0, arm_idx_clr = 0, clr_idx = 0, vel_rst_in = 0;
    logic enc_a = 0, enc_b = 0, enc_idx = 0;
    logic [POS_W-1:0] pos_cnt;
    logic [IDX_W-1:0] rev_cnt;
    logic dir_rev, dir_chg, enc_clk, phase_err, idx_seen, rev_match, vel_rst_out;
    logic [NCMP-1:0] pos_match;

    int tests = 0, fails = 0;
    int n_enc = 0, n_err = 0, n_dchg = 0, n_rmatch = 0;
    int n_pm0 = 0, n_pm1 = 0, n_pm2 = 0;
    bit done = 0;

    always #5 clk = ~clk;

    qenc_counter #(.POS_W(POS_W), .IDX_W(IDX_W), .FLT_W(FLT_W), .NCMP(NCMP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_stepdir(cfg_stepdir), .cfg_x4(cfg_x4),
        .cfg_dir_inv(cfg_dir_inv), .cfg_idx_inv(cfg_idx_inv), .flt_len(flt_len),
        .max_pos(max_pos), .cmp_pos({c2, c1, c0}), .cmp_idx(cmp_idx),
        .clr_pos(clr_pos), .arm_idx_clr(arm_idx_clr), .clr_idx(clr_idx),
        .vel_rst_in(vel_rst_in), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .pos_cnt(pos_cnt), .rev_cnt(rev_cnt), .dir_rev(dir_rev), .dir_chg(dir_chg),
        .enc_clk(enc_clk), .phase_err(phase_err), .idx_seen(idx_seen),
        .pos_match(pos_match), .rev_match(rev_match), .vel_rst_out(vel_rst_out)
    );

    // pulse tallies, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (enc_clk)      n_enc++;
            if (phase_err)    n_err++;
            if (dir_chg)      n_dchg++;
            if (rev_match)    n_rmatch++;
            if (pos_match[0]) n_pm0++;
            if (pos_match[1]) n_pm1++;
            if (pos_match[2]) n_pm2++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (14) @(negedge clk);
    endtask

    task automatic q_step(input bit up);
        @(negedge clk);
        if (up) begin
            if (enc_a == enc_b) enc_a = ~enc_a; else enc_b = ~enc_b;
        end else begin
            if (enc_a == enc_b) enc_b = ~enc_b; else enc_a = ~enc_a;
        end
        settle();
    endtask

    task automatic strobe_clr_pos();
        @(negedge clk) clr_pos = 1;
        @(negedge clk) clr_pos = 0;
        settle();
    endtask

    task automatic set_idx(input logic v);
        @(negedge clk) enc_idx = v;
        settle();
    endtask

    task automatic t_reset();
        chk("R13 position after reset", pos_cnt, 0);
        chk("R13 revolutions after reset", rev_cnt, 0);
        chk("R13 direction after reset", dir_rev, 0);
        chk("R13 pulses after reset", int'(enc_clk) + int'(phase_err) + int'(pos_match), 0);
    endtask

    task automatic t_quad4x();
        int e0, d0;
        e0 = n_enc; d0 = n_dchg;
        for (int i = 0; i < 4; i++) q_step(1);
        chk("R1 four up steps", pos_cnt, 4);
        chk("R12 enc_clk per step", n_enc - e0, 4);
        chk("R7 forward direction", dir_rev, 0);
        q_step(0); q_step(0);
        chk("R1 two down steps", pos_cnt, 2);
        chk("R7 reverse direction", dir_rev, 1);
        chk("R7 one change pulse", n_dchg - d0, 1);
        q_step(1);
        chk("R7 second change pulse", n_dchg - d0, 2);
        chk("R1 back up", pos_cnt, 3);
    endtask

    task automatic t_quad2x();
        strobe_clr_pos();
        chk("R10 clear strobe", pos_cnt, 0);
        cfg_x4 = 0;
        for (int i = 0; i < 4; i++) q_step(1);
        chk("R2 only A edges count", pos_cnt, 2);
        cfg_x4 = 1;
    endtask

    task automatic t_wrap();
        max_pos = 16'd5;
        strobe_clr_pos();
        q_step(0);
        chk("R5 down from zero", pos_cnt, 5);
        q_step(1);
        chk("R5 up from max", pos_cnt, 0);
        q_step(1);
        chk("R5 after wrap", pos_cnt, 1);
        max_pos = 16'd1000;
    endtask

    task automatic t_error();
        int e0, c0n;
        e0 = n_err; c0n = n_enc;
        @(negedge clk) begin enc_a = ~enc_a; enc_b = ~enc_b; end
        settle();
        chk("R6 error pulse", n_err - e0, 1);
        chk("R6 position held", pos_cnt, 1);
        chk("R6 no count event", n_enc - c0n, 0);
        q_step(1);
        chk("R6 counting resumes", pos_cnt, 2);
    endtask

    task automatic t_invert();
        cfg_dir_inv = 1;
        q_step(1);
        chk("R4 inverted count", pos_cnt, 1);
        chk("R4 inverted status", dir_rev, 1);
        cfg_dir_inv = 0;
    endtask

    task automatic t_stepdir();
        cfg_stepdir = 1;
        @(negedge clk) begin enc_a = 0; enc_b = 0; end
        settle();
        strobe_clr_pos();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) enc_a = 1; settle();
            @(negedge clk) enc_a = 0; settle();
        end
        chk("R3 three forward steps", pos_cnt, 3);
        @(negedge clk) enc_b = 1; settle();
        chk("R3 direction pin alone", pos_cnt, 3);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk) enc_a = 1; settle();
            @(negedge clk) enc_a = 0; settle();
        end
        chk("R3 two reverse steps", pos_cnt, 1);
        @(negedge clk) enc_b = 0; settle();
        cfg_stepdir = 0;
    endtask

    task automatic t_filter();
        int e0;
        flt_len = 4'd6;
        e0 = n_enc;
        @(negedge clk) enc_a = ~enc_a;
        repeat (3) @(negedge clk);
        enc_a = ~enc_a;
        settle();
        chk("R8 glitch position", pos_cnt, 1);
        chk("R8 glitch no event", n_enc - e0, 0);
        q_step(1);
        chk("R8 held level counts", pos_cnt, 2);
        flt_len = 4'd2;
    endtask

    task automatic t_index();
        int m0;
        m0 = n_rmatch;
        set_idx(1);
        chk("R9 first index", rev_cnt, 1);
        set_idx(0);
        chk("R9 falling ignored", rev_cnt, 1);
        cmp_idx = 8'd2;
        set_idx(1);
        chk("R9 second index", rev_cnt, 2);
        chk("R9 compare pulse", n_rmatch - m0, 1);
        set_idx(0);
        set_idx(1);
        chk("R9 third index", rev_cnt, 3);
        @(negedge clk) cfg_idx_inv = 1; settle();
        chk("R9 polarity switch no count", rev_cnt, 3);
        set_idx(0);
        chk("R9 inverted index counts low", rev_cnt, 4);
        set_idx(1);
        chk("R9 inverted rise ignored", rev_cnt, 4);
        set_idx(0);
        @(negedge clk) cfg_idx_inv = 0; settle();
        @(negedge clk) clr_idx = 1;
        @(negedge clk) clr_idx = 0;
        settle();
        chk("R9 clear revolutions", rev_cnt, 0);
        chk("R9 compare pulses total", n_rmatch - m0, 1);
    endtask

    task automatic t_arm();
        strobe_clr_pos();
        for (int i = 0; i < 3; i++) q_step(1);
        @(negedge clk) arm_idx_clr = 1;
        @(negedge clk) arm_idx_clr = 0;
        q_step(1); q_step(1);
        chk("R10 armed not yet cleared", pos_cnt, 5);
        set_idx(1);
        chk("R10 clear on index", pos_cnt, 0);
        set_idx(0);
        for (int i = 0; i < 3; i++) q_step(1);
        @(negedge clk) arm_idx_clr = 1;
        @(negedge clk) arm_idx_clr = 0;
        @(negedge clk) begin
            if (enc_a == enc_b) enc_a = ~enc_a; else enc_b = ~enc_b;
            enc_idx = 1;
        end
        settle();
        chk("R10 index clear beats count", pos_cnt, 0);
        q_step(1);
        chk("R10 arm used once", pos_cnt, 1);
        set_idx(0);
    endtask

    task automatic t_match();
        int a0, a1, a2;
        c0 = 16'd3; c1 = 16'd5; c2 = 16'd7;
        strobe_clr_pos();
        a0 = n_pm0; a1 = n_pm1; a2 = n_pm2;
        for (int i = 0; i < 7; i++) q_step(1);
        chk("R11 position reached", pos_cnt, 7);
        chk("R11 channel 0", n_pm0 - a0, 1);
        chk("R11 channel 1", n_pm1 - a1, 1);
        chk("R11 channel 2", n_pm2 - a2, 1);
        q_step(0); q_step(0);
        chk("R11 channel 1 again", n_pm1 - a1, 2);
        chk("R11 channel 2 once", n_pm2 - a2, 1);
    endtask

    task automatic t_vel();
        @(negedge clk) vel_rst_in = 1;
        chk("R12 velocity reset not yet", vel_rst_out, 0);
        @(negedge clk) vel_rst_in = 0;
        chk("R12 velocity reset passed", vel_rst_out, 1);
        @(negedge clk);
        chk("R12 velocity reset ends", vel_rst_out, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_quad4x();
        t_quad2x();
        t_wrap();
        t_error();
        t_invert();
        t_stepdir();
        t_filter();
        t_index();
        t_arm();
        t_match();
        t_vel();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule